// File: doc/BRIEF.md
# Multi-Channel Complex Test Pattern Generator

This block produces synthetic complex sample streams on several independent channels, eight by default, one per station stream. Each channel has a real part and an imaginary part, and each part runs its own arithmetic sequence. A sequence can stay flat at a constant value, rise by a fixed increment on every sample, or fall by that increment. Each channel also waits a programmable number of sample cycles before its first output.

A control agent writes each channel's settings through a simple write-only register port. It then pulses a start input to launch every channel at once and a stop input to halt them. A separate clear input returns every setting to its default and also halts generation. Each channel drives a valid flag and one signed sample per part. Downstream logic takes a sample on every cycle in which that channel's valid is high.

Top module: `tpg_top`

## Requirements
- R1: After synchronous reset, all valid outputs are low, and every channel holds its default settings: delay 0, initial value 0, increment 0, flat mode.
- R2: A write puts `cfg_wdata` into the setting selected by `cfg_addr`. The upper address bits select the channel and the low 3 bits select the field: 0 delay, 1 real initial value, 2 real increment, 3 real mode, 4 imaginary initial value, 5 imaginary increment, 6 imaginary mode. A write with field code 7 changes nothing.
- R3: After a start pulse, each channel keeps its valid low for the number of cycles held in its delay setting. Valid then goes high and stays high until the next stop, clear or start.
- R4: The first valid sample of each part equals that part's initial value. Initial values are two's-complement signed.
- R5: Mode code 0 (flat) holds a part at its current value. Mode code 3 behaves the same way.
- R6: Mode code 1 (ramp-up) adds the increment on every valid cycle and wraps modulo 2^SAMPLE_W.
- R7: Mode code 2 (ramp-down) subtracts the increment on every valid cycle and wraps modulo 2^SAMPLE_W.
- R8: The real and imaginary parts sequence independently. Writes to one channel do not affect any other channel.
- R9: A stop pulse drops every valid output in the cycle after its edge. When stop and start arrive in the same cycle, stop wins.
- R10: A start pulse always reloads every channel's delay and initial values, whether generation is running or stopped.
- R11: A clear pulse returns every setting to its default and drops every valid output in the following cycle.
- R12: A change to an increment or a mode is used from the next sequence step onward. A change to a delay or an initial value takes effect only at the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Setting write strobe |
| cfg_addr | input | log2(NUM_CH)+3 | Channel index in the upper bits, field code in bits 2:0 |
| cfg_wdata | input | CFG_DW | Write data; low bits used per field |
| defaults_load | input | 1 | Return all settings to defaults and halt |
| gen_start | input | 1 | Start (or restart) generation on all channels |
| gen_stop | input | 1 | Stop generation on all channels |
| smp_valid | output | NUM_CH | Per-channel sample valid |
| smp_re | output | NUM_CH x SAMPLE_W | Per-channel real sample |
| smp_im | output | NUM_CH x SAMPLE_W | Per-channel imaginary sample |

## Verification
The bench builds the block with four channels, 8-bit samples and a 6-bit delay counter. With 8-bit samples, a ramp wraps past the signed extremes within a few steps, so wrap-around in both directions is checked inside short windows. With only four channels, each test can compare one programmed channel against a neighbour left at its defaults. The 6-bit delay keeps each start-up wait short enough to check on every cycle, including the zero-delay case.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    localparam int FIELD_W = 3;

    typedef enum logic [1:0] {
        PAT_FLAT = 2'd0,
        PAT_RISE = 2'd1,
        PAT_FALL = 2'd2,
        PAT_HOLD = 2'd3
    } pat_mode_e;

    typedef enum logic [FIELD_W-1:0] {
        FLD_DELAY   = 3'd0,
        FLD_RE_INIT = 3'd1,
        FLD_RE_STEP = 3'd2,
        FLD_RE_MODE = 3'd3,
        FLD_IM_INIT = 3'd4,
        FLD_IM_STEP = 3'd5,
        FLD_IM_MODE = 3'd6,
        FLD_SPARE   = 3'd7
    } cfg_field_e;

    // True when the mode advances the value on each valid cycle
    function automatic logic mode_moves(input logic [1:0] m);
        return (m == PAT_RISE) || (m == PAT_FALL);
    endfunction

endpackage

// File: rtl/tpg_cfg_regs.sv
module tpg_cfg_regs
    import tpg_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int SAMPLE_W = 16,
    parameter int DELAY_W  = 16,
    parameter int CFG_DW   = 32,
    parameter int ADDR_W   = $clog2(NUM_CH) + FIELD_W
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                clear,
    input  logic                                we,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [CFG_DW-1:0]                   wdata,
    output logic [NUM_CH-1:0][DELAY_W-1:0]      delay_q,
    output logic [NUM_CH-1:0][SAMPLE_W-1:0]     re_init_q,
    output logic [NUM_CH-1:0][SAMPLE_W-1:0]     re_step_q,
    output logic [NUM_CH-1:0][1:0]              re_mode_q,
    output logic [NUM_CH-1:0][SAMPLE_W-1:0]     im_init_q,
    output logic [NUM_CH-1:0][SAMPLE_W-1:0]     im_step_q,
    output logic [NUM_CH-1:0][1:0]              im_mode_q
);
    localparam int CH_AW = ADDR_W - FIELD_W;

    cfg_field_e field;
    logic [CH_AW-1:0] ch_sel;

    always_comb begin
        field  = cfg_field_e'(addr[FIELD_W-1:0]);
        ch_sel = addr[ADDR_W-1:FIELD_W];
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit;
        always_comb hit = we && (ch_sel == CH_AW'(c));

        always_ff @(posedge clk) begin
            if (rst || clear) begin
                delay_q[c]   <= '0;
                re_init_q[c] <= '0;
                re_step_q[c] <= '0;
                re_mode_q[c] <= PAT_FLAT;
                im_init_q[c] <= '0;
                im_step_q[c] <= '0;
                im_mode_q[c] <= PAT_FLAT;
            end else if (hit) begin
                case (field)
                    FLD_DELAY:   delay_q[c]   <= wdata[DELAY_W-1:0];
                    FLD_RE_INIT: re_init_q[c] <= wdata[SAMPLE_W-1:0];
                    FLD_RE_STEP: re_step_q[c] <= wdata[SAMPLE_W-1:0];
                    FLD_RE_MODE: re_mode_q[c] <= wdata[1:0];
                    FLD_IM_INIT: im_init_q[c] <= wdata[SAMPLE_W-1:0];
                    FLD_IM_STEP: im_step_q[c] <= wdata[SAMPLE_W-1:0];
                    FLD_IM_MODE: im_mode_q[c] <= wdata[1:0];
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/tpg_part_seq.sv
module tpg_part_seq
    import tpg_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         adv,
    input  logic [W-1:0] init,
    input  logic [W-1:0] step,
    input  logic [1:0]   mode,
    output logic [W-1:0] value
);
    logic [W-1:0] nxt;

    always_comb begin
        case (pat_mode_e'(mode))
            PAT_RISE: nxt = value + step;
            PAT_FALL: nxt = value - step;
            default:  nxt = value;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            value <= '0;
        else if (load)
            value <= init;
        else if (adv && mode_moves(mode))
            value <= nxt;
    end

endmodule

// File: rtl/tpg_channel.sv
module tpg_channel
    import tpg_pkg::*;
#(
    parameter int SAMPLE_W = 16,
    parameter int DELAY_W  = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                halt,
    input  logic [DELAY_W-1:0]  delay,
    input  logic [SAMPLE_W-1:0] re_init,
    input  logic [SAMPLE_W-1:0] re_step,
    input  logic [1:0]          re_mode,
    input  logic [SAMPLE_W-1:0] im_init,
    input  logic [SAMPLE_W-1:0] im_step,
    input  logic [1:0]          im_mode,
    output logic                valid,
    output logic [SAMPLE_W-1:0] re,
    output logic [SAMPLE_W-1:0] im
);
    logic               run_q;
    logic [DELAY_W-1:0] wait_q;
    logic               load;

    always_comb begin
        valid = run_q && (wait_q == '0);
        load  = start && !halt;
    end

    always_ff @(posedge clk) begin
        if (rst || halt) begin
            run_q  <= 1'b0;
            wait_q <= '0;
        end else if (start) begin
            run_q  <= 1'b1;
            wait_q <= delay;
        end else if (run_q && wait_q != '0) begin
            wait_q <= wait_q - 1'b1;
        end
    end

    tpg_part_seq #(.W(SAMPLE_W)) u_re (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .adv   (valid),
        .init  (re_init),
        .step  (re_step),
        .mode  (re_mode),
        .value (re)
    );

    tpg_part_seq #(.W(SAMPLE_W)) u_im (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .adv   (valid),
        .init  (im_init),
        .step  (im_step),
        .mode  (im_mode),
        .value (im)
    );

endmodule

// File: rtl/tpg_top.sv
module tpg_top
    import tpg_pkg::*;
#(
    parameter int NUM_CH   = 8,
    parameter int SAMPLE_W = 16,
    parameter int DELAY_W  = 16,
    parameter int CFG_DW   = 32,
    localparam int ADDR_W  = $clog2(NUM_CH) + FIELD_W
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            cfg_we,
    input  logic [ADDR_W-1:0]               cfg_addr,
    input  logic [CFG_DW-1:0]               cfg_wdata,
    input  logic                            defaults_load,
    input  logic                            gen_start,
    input  logic                            gen_stop,
    output logic [NUM_CH-1:0]               smp_valid,
    output logic [NUM_CH-1:0][SAMPLE_W-1:0] smp_re,
    output logic [NUM_CH-1:0][SAMPLE_W-1:0] smp_im
);
    logic [NUM_CH-1:0][DELAY_W-1:0]  delay_q;
    logic [NUM_CH-1:0][SAMPLE_W-1:0] re_init_q, re_step_q, im_init_q, im_step_q;
    logic [NUM_CH-1:0][1:0]          re_mode_q, im_mode_q;
    logic                            halt;

    always_comb halt = gen_stop || defaults_load;

    tpg_cfg_regs #(
        .NUM_CH   (NUM_CH),
        .SAMPLE_W (SAMPLE_W),
        .DELAY_W  (DELAY_W),
        .CFG_DW   (CFG_DW),
        .ADDR_W   (ADDR_W)
    ) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .clear     (defaults_load),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .delay_q   (delay_q),
        .re_init_q (re_init_q),
        .re_step_q (re_step_q),
        .re_mode_q (re_mode_q),
        .im_init_q (im_init_q),
        .im_step_q (im_step_q),
        .im_mode_q (im_mode_q)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        tpg_channel #(
            .SAMPLE_W (SAMPLE_W),
            .DELAY_W  (DELAY_W)
        ) u_chan (
            .clk     (clk),
            .rst     (rst),
            .start   (gen_start),
            .halt    (halt),
            .delay   (delay_q[c]),
            .re_init (re_init_q[c]),
            .re_step (re_step_q[c]),
            .re_mode (re_mode_q[c]),
            .im_init (im_init_q[c]),
            .im_step (im_step_q[c]),
            .im_mode (im_mode_q[c]),
            .valid   (smp_valid[c]),
            .re      (smp_re[c]),
            .im      (smp_im[c])
        );
    end

endmodule

// File: rtl/tpg_checker.sv
module tpg_checker
#(
    parameter int NUM_CH   = 8,
    parameter int SAMPLE_W = 16
) (
    input logic                            clk,
    input logic                            rst,
    input logic                            gen_start,
    input logic                            gen_stop,
    input logic                            defaults_load,
    input logic [NUM_CH-1:0]               smp_valid,
    input logic [NUM_CH-1:0][SAMPLE_W-1:0] smp_re,
    input logic [NUM_CH-1:0][SAMPLE_W-1:0] smp_im,
    input logic [NUM_CH-1:0][SAMPLE_W-1:0] re_step,
    input logic [NUM_CH-1:0][1:0]          re_mode,
    input logic [NUM_CH-1:0][SAMPLE_W-1:0] im_step,
    input logic [NUM_CH-1:0][1:0]          im_mode
);
    assert_stop_clears_R9: assert property (@(posedge clk) disable iff (rst)
        gen_stop |=> (smp_valid == '0));

    assert_defaults_halt_R11: assert property (@(posedge clk) disable iff (rst)
        defaults_load |=> (smp_valid == '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        assert_valid_holds_R3: assert property (@(posedge clk) disable iff (rst)
            (smp_valid[c] && !gen_start && !gen_stop && !defaults_load) |=> smp_valid[c]);

        assert_re_rise_R6: assert property (@(posedge clk) disable iff (rst)
            ($past(smp_valid[c]) && !$past(rst) && !$past(gen_start) && !$past(gen_stop)
             && !$past(defaults_load) && $past(re_mode[c]) == 2'd1)
            |-> smp_re[c] == SAMPLE_W'($past(smp_re[c]) + $past(re_step[c])));

        assert_im_fall_R7: assert property (@(posedge clk) disable iff (rst)
            ($past(smp_valid[c]) && !$past(rst) && !$past(gen_start) && !$past(gen_stop)
             && !$past(defaults_load) && $past(im_mode[c]) == 2'd2)
            |-> smp_im[c] == SAMPLE_W'($past(smp_im[c]) - $past(im_step[c])));

        assert_re_flat_R5: assert property (@(posedge clk) disable iff (rst)
            ($past(smp_valid[c]) && !$past(rst) && !$past(gen_start) && !$past(defaults_load)
             && ($past(re_mode[c]) == 2'd0 || $past(re_mode[c]) == 2'd3))
            |-> $stable(smp_re[c]));
    end

endmodule

bind tpg_top tpg_checker #(
    .NUM_CH   (NUM_CH),
    .SAMPLE_W (SAMPLE_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .gen_start     (gen_start),
    .gen_stop      (gen_stop),
    .defaults_load (defaults_load),
    .smp_valid     (smp_valid),
    .smp_re        (smp_re),
    .smp_im        (smp_im),
    .re_step       (re_step_q),
    .re_mode       (re_mode_q),
    .im_step       (im_step_q),
    .im_mode       (im_mode_q)
);

// File: tb/sim_tpg_top.sv
module sim_tpg_top;
    localparam int NCH = 4;
    localparam int SW  = 8;
    localparam int DW  = 6;
    localparam int CDW = 16;
    localparam int AW  = $clog2(NCH) + 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [CDW-1:0] cfg_wdata = '0;
    logic defaults_load = 1'b0, gen_start = 1'b0, gen_stop = 1'b0;
    logic [NCH-1:0] smp_valid;
    logic [NCH-1:0][SW-1:0] smp_re, smp_im;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    tpg_top #(.NUM_CH(NCH), .SAMPLE_W(SW), .DELAY_W(DW), .CFG_DW(CDW)) u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .defaults_load(defaults_load),
        .gen_start(gen_start), .gen_stop(gen_stop),
        .smp_valid(smp_valid), .smp_re(smp_re), .smp_im(smp_im)
    );

    typedef struct packed {
        logic [1:0]    ch;
        logic [DW-1:0] dly;
        logic [SW-1:0] re_init;
        logic [SW-1:0] re_inc;
        logic [1:0]    re_mode;
        logic [SW-1:0] im_init;
        logic [SW-1:0] im_inc;
        logic [1:0]    im_mode;
    } vec_t;

    localparam int NVEC = 4;
    localparam vec_t VEC [NVEC] = '{
        '{2'd0, 6'd5, 8'd12,  8'd1,  2'd1, 8'd12,  8'd5,  2'd1},
        '{2'd1, 6'd3, 8'd100, 8'd0,  2'd0, 8'hCE,  8'd2,  2'd2},
        '{2'd3, 6'd0, 8'd120, 8'd10, 2'd1, 8'h88,  8'd10, 2'd2},
        '{2'd2, 6'd1, 8'hFF,  8'd7,  2'd3, 8'h7F,  8'd1,  2'd1}
    };

    function automatic logic [SW-1:0] model(input logic [SW-1:0] init,
                                            input logic [SW-1:0] inc,
                                            input logic [1:0] mode, input int j);
        case (mode)
            2'd1:    return init + SW'(j) * inc;
            2'd2:    return init - SW'(j) * inc;
            default: return init;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input int ch, input int fld, input logic [CDW-1:0] d);
        cfg_we = 1'b1;
        cfg_addr = {2'(ch), 3'(fld)};
        cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic pulse_start();
        gen_start = 1'b1; tick(); gen_start = 1'b0;
    endtask

    task automatic pulse_stop();
        gen_stop = 1'b1; tick(); gen_stop = 1'b0;
    endtask

    task automatic pulse_def();
        defaults_load = 1'b1; tick(); defaults_load = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 valid low in reset", 32'(smp_valid), 0);
        rst = 1'b0;
        tick();
        chk("R1 valid low after reset", 32'(smp_valid), 0);
        // R1: defaults give immediate flat zero output
        pulse_start();
        chk("R1 default valid at start", 32'(smp_valid), 32'hF);
        chk("R1 default real zero", 32'(smp_re[0]), 0);
        tick(); tick();
        chk("R1 default stays zero", 32'(smp_im[2]), 0);
        pulse_stop();

        // Vector table: one programmed channel per entry
        for (int v = 0; v < NVEC; v++) begin
            int ch = int'(VEC[v].ch);
            int other = (ch + 1) % NCH;
            pulse_def();
            wr(ch, 0, CDW'(VEC[v].dly));
            wr(ch, 1, CDW'(VEC[v].re_init));
            wr(ch, 2, CDW'(VEC[v].re_inc));
            wr(ch, 3, CDW'(VEC[v].re_mode));
            wr(ch, 4, CDW'(VEC[v].im_init));
            wr(ch, 5, CDW'(VEC[v].im_inc));
            wr(ch, 6, CDW'(VEC[v].im_mode));
            pulse_start();
            chk("R8 neighbour valid", 32'(smp_valid[other]), 1);
            chk("R8 neighbour real untouched", 32'(smp_re[other]), 0);
            for (int i = 0; i < int'(VEC[v].dly); i++) begin
                chk("R3 valid low during delay", 32'(smp_valid[ch]), 0);
                tick();
            end
            for (int j = 0; j < 6; j++) begin
                chk("R3 valid high after delay", 32'(smp_valid[ch]), 1);
                chk((j == 0) ? "R4 real first sample" : "R5/R6/R7 real sequence",
                    32'(smp_re[ch]), 32'(model(VEC[v].re_init, VEC[v].re_inc, VEC[v].re_mode, j)));
                chk((j == 0) ? "R4 imag first sample" : "R6/R7 imag sequence",
                    32'(smp_im[ch]), 32'(model(VEC[v].im_init, VEC[v].im_inc, VEC[v].im_mode, j)));
                tick();
            end
        end

        // R9: stop drops valid
        pulse_stop();
        chk("R9 stop drops valid", 32'(smp_valid), 0);
        gen_start = 1'b1; gen_stop = 1'b1; tick(); gen_start = 1'b0; gen_stop = 1'b0;
        chk("R9 stop beats start", 32'(smp_valid), 0);
        tick();
        chk("R9 still idle", 32'(smp_valid), 0);

        // R10: restart reloads delay and initial value
        pulse_def();
        wr(0, 0, 2); wr(0, 1, 10); wr(0, 2, 3); wr(0, 3, 1);
        pulse_start();
        chk("R10 delay 1st", 32'(smp_valid[0]), 0); tick();
        chk("R10 delay 2nd", 32'(smp_valid[0]), 0); tick();
        chk("R10 first value", 32'(smp_re[0]), 10); tick();
        chk("R6 step", 32'(smp_re[0]), 13); tick();
        chk("R6 step", 32'(smp_re[0]), 16);
        pulse_start();
        chk("R10 restart reloads delay", 32'(smp_valid[0]), 0); tick();
        chk("R10 restart delay 2nd", 32'(smp_valid[0]), 0); tick();
        chk("R10 restart reloads init", 32'(smp_re[0]), 10);
        pulse_stop();
        pulse_start();
        tick(); tick();
        chk("R10 start after stop", 32'(smp_re[0]), 10);

        // R11: clear during run
        pulse_def();
        chk("R11 clear drops valid", 32'(smp_valid), 0);
        pulse_start();
        chk("R11 delay back to zero", 32'(smp_valid[0]), 1);
        chk("R11 init back to zero", 32'(smp_re[0]), 0);
        tick();
        chk("R11 mode back to flat", 32'(smp_re[0]), 0);

        // R12 and R2: live increment, deferred init, spare field
        pulse_def();
        wr(0, 2, 1); wr(0, 3, 1);
        pulse_start();
        chk("R12 ramp start", 32'(smp_re[0]), 0);
        wr(0, 2, 4);
        chk("R12 old step on write edge", 32'(smp_re[0]), 1);
        tick();
        chk("R12 new step used", 32'(smp_re[0]), 5);
        wr(0, 1, 50);
        chk("R12 init write deferred", 32'(smp_re[0]), 9);
        wr(0, 7, 16'hFFFF);
        chk("R2 spare field ignored", 32'(smp_re[0]), 13);
        tick();
        chk("R2 spare field no effect", 32'(smp_re[0]), 17);
        chk("R2 imag untouched", 32'(smp_im[0]), 0);
        pulse_start();
        chk("R12 init applies at start", 32'(smp_re[0]), 50);
        tick();
        chk("R12 step kept after start", 32'(smp_re[0]), 54);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule